// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank, 32-bit DDR SDRAM interface. It takes the memory from power-on to an idle state that is ready for use. After reset it keeps the clock-enable pin low and deselects the device. It stays that way until a stable-clock interval has run out. That interval is given in picoseconds and converted to clock cycles from the clock period.

It then raises clock enable and drives one NOP cycle. After that it sends a fixed series of commands, with the configured minimum spacing between each one:

1. precharge of all banks
2. extended mode register write (DLL enabled, selectable drive strength)
3. mode register write with the DLL-reset bit set
4. a second precharge of all banks
5. two auto-refreshes
6. a final mode register write with the DLL-reset bit clear

Every cycle that carries no command is a NOP. The block raises a sticky done flag once two conditions are met: the final mode-register interval has expired, and a DLL lock window has passed since the DLL reset.

The mode word takes its burst length code and burst ordering from configuration inputs. CAS latency also comes from an input. If that input holds an unsupported value, the block picks the latency from the clock period: 3 at 200 MHz or below, 4 up to 250 MHz, and 5 above that.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, cke is 0, csN is 1 and initDone is 0.
- R2: After reset is released, cke stays low for exactly STABLE_CYC cycles, where STABLE_CYC is the ceiling of STABLE_PS/CLK_PS. It then rises and stays high until the next reset.
- R3: While cke is low, csN is 1 (deselect). Once cke is high, every cycle without a command is a NOP: {csN,rasN,casN,weN} = 0111.
- R4: After cke rises, exactly seven commands are issued, one cycle each, in this order: PRE, EMRS, MRS, PRE, REF, REF, MRS. The pin codes {csN,rasN,casN,weN} are PRE = 0010, REF = 0001, and MRS/EMRS = 0000.
- R5: The first PRE comes one cycle after cke rises. Each next command follows the one before it by a fixed number of cycles: T_RP after a PRE, T_MRD after an EMRS or MRS, and T_RFC after a REF.
- R6: Every PRE drives addr[10] high, which selects all banks.
- R7: The EMRS drives ba = 01, addr[0] = 0 (DLL enabled), addr[1] = DRV_HALF, and all other address bits 0.
- R8: Both MRS commands drive ba = 00, addr[2:0] = cfgBurstLen, addr[3] = cfgInterleave, addr[6:4] = CAS latency, addr[7] = 0 and the upper bits 0. addr[8] is 1 on the first MRS (DLL reset) and 0 on the final one.
- R9: A cfgCasLat value of 3, 4 or 5 is used as given. Any other value selects the latency from CLK_PS: 3 if CLK_PS >= 5000, 4 if CLK_PS >= 4000, and 5 otherwise.
- R10: initDone rises at whichever comes later: T_MRD cycles after the final MRS, or DLL_LOCK cycles after the DLL-reset MRS. From then until reset it stays high and only NOPs are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCasLat | input | 3 | Requested CAS latency; a value outside 3..5 selects automatic choice |
| cfgBurstLen | input | 3 | Burst length code placed in the mode word |
| cfgInterleave | input | 1 | Burst ordering: 1 interleaved, 0 sequential |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus carrying command operands |
| initDone | output | 1 | High once initialization is complete |

## Verification
Every pin, including initDone, is registered once after the control state. A command therefore shows on the pins the cycle after the control reaches its step, and all intervals seen at the pins equal the intervals inside the control.

The bench samples on the falling edge and numbers each sample from the release of reset. It records the sample index of the cke rise, of each command and of the done rise. From those indices it checks the exact STABLE_CYC low window, the one-cycle gap before the first precharge, each T_RP/T_MRD/T_RFC spacing, and the done time. The done time is the later of the final MRS plus T_MRD and the DLL-reset MRS plus DLL_LOCK.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_EMRS,
    CMD_MRS_DLL,
    CMD_REF,
    CMD_MRS
  } initCmdE;

  typedef struct packed {
    logic    ckeOn;
    initCmdE cmd;
    logic    doneOn;
  } seqStrobeT;

  localparam int STEP_W = 3;

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int STABLE_CYC = 50000,
  parameter int T_RP       = 4,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 20,
  parameter int DLL_LOCK   = 200
) (
  input  logic      clk,
  input  logic      rstN,
  output seqStrobeT strobe
);

  localparam int GAP_A   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int GAP_MAX = (GAP_A > T_RFC) ? GAP_A : T_RFC;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam int SW      = $clog2(STABLE_CYC + 1);
  localparam int DW      = $clog2(DLL_LOCK + 1);

  typedef enum logic [1:0] {S_STABLE, S_RUN, S_DONE} stateE;

  stateE               state;
  logic [SW-1:0]       stableCnt;
  logic [STEP_W-1:0]   step;
  logic [GW-1:0]       gapCnt;
  logic [DW-1:0]       dllCnt;
  logic                issue;
  logic                lastCyc;
  logic                dllOk;
  logic [GW-1:0]       stepGap;
  initCmdE             stepCmd;

  // Command and minimum spacing to the next command for each step.
  always_comb begin
    unique case (step)
      3'd0:    begin stepCmd = CMD_NOP;     stepGap = GW'(1);     end
      3'd1:    begin stepCmd = CMD_PRE;     stepGap = GW'(T_RP);  end
      3'd2:    begin stepCmd = CMD_EMRS;    stepGap = GW'(T_MRD); end
      3'd3:    begin stepCmd = CMD_MRS_DLL; stepGap = GW'(T_MRD); end
      3'd4:    begin stepCmd = CMD_PRE;     stepGap = GW'(T_RP);  end
      3'd5:    begin stepCmd = CMD_REF;     stepGap = GW'(T_RFC); end
      3'd6:    begin stepCmd = CMD_REF;     stepGap = GW'(T_RFC); end
      default: begin stepCmd = CMD_MRS;     stepGap = GW'(T_MRD); end
    endcase
  end

  assign issue   = (state == S_RUN) && (gapCnt == '0);
  assign lastCyc = (gapCnt == stepGap - GW'(1));
  assign dllOk   = (dllCnt >= DW'(DLL_LOCK - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_STABLE;
      stableCnt <= '0;
      step      <= '0;
      gapCnt    <= '0;
      dllCnt    <= '0;
    end else begin
      unique case (state)
        S_STABLE: begin
          if (stableCnt == SW'(STABLE_CYC - 1)) state <= S_RUN;
          else                                  stableCnt <= stableCnt + SW'(1);
        end
        S_RUN: begin
          if (issue && step == 3'd3)           dllCnt <= DW'(1);
          else if (dllCnt != '0 && !dllOk)     dllCnt <= dllCnt + DW'(1);
          if (lastCyc) begin
            if (step == 3'd7) begin
              if (dllOk) state <= S_DONE;
            end else begin
              step   <= step + STEP_W'(1);
              gapCnt <= '0;
            end
          end else begin
            gapCnt <= gapCnt + GW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.ckeOn  = (state != S_STABLE);
    strobe.cmd    = issue ? stepCmd : CMD_NOP;
    strobe.doneOn = (state == S_DONE);
  end

endmodule

// File: rtl/ddr_init_pins.sv
module ddr_init_pins
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int CLK_PS   = 4000,
  parameter bit DRV_HALF = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgInterleave,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam logic [2:0] AUTO_CL = (CLK_PS >= 5000) ? 3'd3 :
                                   (CLK_PS >= 4000) ? 3'd4 : 3'd5;
  localparam int A_ALLBANK = 10;
  localparam int A_DLLRST  = 8;

  logic [2:0]        casLat;
  logic [ADDR_W-1:0] modeWord;
  logic [3:0]        pinNxt;
  logic [BA_W-1:0]   baNxt;
  logic [ADDR_W-1:0] addrNxt;

  always_comb begin
    casLat = (cfgCasLat >= 3'd3 && cfgCasLat <= 3'd5) ? cfgCasLat : AUTO_CL;
    modeWord      = '0;
    modeWord[2:0] = cfgBurstLen;
    modeWord[3]   = cfgInterleave;
    modeWord[6:4] = casLat;
  end

  always_comb begin
    pinNxt  = 4'b0111;
    baNxt   = '0;
    addrNxt = '0;
    unique case (strobe.cmd)
      CMD_PRE: begin
        pinNxt             = 4'b0010;
        addrNxt[A_ALLBANK] = 1'b1;
      end
      CMD_EMRS: begin
        pinNxt     = 4'b0000;
        baNxt      = BA_W'(1);
        addrNxt[0] = 1'b0;
        addrNxt[1] = DRV_HALF;
      end
      CMD_MRS_DLL: begin
        pinNxt            = 4'b0000;
        addrNxt           = modeWord;
        addrNxt[A_DLLRST] = 1'b1;
      end
      CMD_REF: pinNxt = 4'b0001;
      CMD_MRS: begin
        pinNxt  = 4'b0000;
        addrNxt = modeWord;
      end
      default: ;
    endcase
    if (!strobe.ckeOn) pinNxt = 4'b1111;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke      <= 1'b0;
      {csN, rasN, casN, weN} <= 4'b1111;
      ba       <= '0;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      cke      <= strobe.ckeOn;
      {csN, rasN, casN, weN} <= pinNxt;
      ba       <= baNxt;
      addr     <= addrNxt;
      initDone <= strobe.doneOn;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int CLK_PS    = 4000,
  parameter int STABLE_PS = 200_000_000,
  parameter int T_RP      = 4,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 20,
  parameter int DLL_LOCK  = 200,
  parameter bit DRV_HALF  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgInterleave,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int STABLE_CYC = (STABLE_PS + CLK_PS - 1) / CLK_PS;

  seqStrobeT strobe;

  ddr_init_ctrl #(
    .STABLE_CYC(STABLE_CYC), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK)
  ) ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  ddr_init_pins #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CLK_PS(CLK_PS), .DRV_HALF(DRV_HALF)
  ) pins (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgCasLat(cfgCasLat), .cfgBurstLen(cfgBurstLen), .cfgInterleave(cfgInterleave),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .initDone(initDone)
  );

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              initDone
);

  logic isPre, isMrs, isNop;
  assign isPre = !csN && !rasN &&  casN && !weN;
  assign isMrs = !csN && !rasN && !casN && !weN;
  assign isNop = !csN &&  rasN &&  casN &&  weN;

  a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);

  a_r3_deselect_while_low: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> csN);

  a_r6_precharge_all: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> addr[10]);

  a_r7_emrs_dll_on: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && ba == BA_W'(1)) |-> !addr[0]);

  a_r8_mrs_test_clear: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && ba == '0) |-> !addr[7]);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cke && isNop));

endmodule

bind ddr_init_seq ddr_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .addr(addr), .initDone(initDone)
);

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;

  localparam int ADDR_W     = 12;
  localparam int BA_W       = 2;
  localparam int CLK_PS     = 4000;
  localparam int STABLE_PS  = 400_000;
  localparam int STABLE_CYC = 100;
  localparam int T_RP       = 4;
  localparam int T_MRD      = 2;
  localparam int T_RFC      = 12;
  localparam int DLL_LOCK   = 60;
  localparam bit DRV_HALF   = 1'b1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        cfgCasLat = 3'd4;
  logic [2:0]        cfgBurstLen = 3'd2;
  logic              cfgInterleave = 1'b0;
  logic              cke, csN, rasN, casN, weN, initDone;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CLK_PS(CLK_PS), .STABLE_PS(STABLE_PS),
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK),
    .DRV_HALF(DRV_HALF)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgCasLat(cfgCasLat), .cfgBurstLen(cfgBurstLen),
    .cfgInterleave(cfgInterleave), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .initDone(initDone)
  );

  always #2 clk = ~clk;

  int nCmp = 0;
  int nBad = 0;

  int                cmdT[8];
  logic [3:0]        cmdCode[8];
  logic [BA_W-1:0]   cmdBa[8];
  logic [ADDR_W-1:0] cmdAddr[8];
  int nCmd, lowCnt, riseIdx, doneIdx;
  bit ckeDrop, deselBad, postBad, doneDrop;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // Apply configuration, reset, then record the pin activity after release.
  task automatic runInit(input logic [2:0] cl, input logic [2:0] bl, input logic inter);
    cfgCasLat = cl; cfgBurstLen = bl; cfgInterleave = inter;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    nCmd = 0; lowCnt = 0; riseIdx = 0; doneIdx = 0;
    ckeDrop = 0; deselBad = 0; postBad = 0; doneDrop = 0;
    rstN = 1'b1;
    for (int idx = 1; idx < 3000; idx++) begin
      @(negedge clk);
      if (!cke) begin
        if (riseIdx == 0) lowCnt++; else ckeDrop = 1;
        if (csN !== 1'b1) deselBad = 1;
      end else begin
        if (riseIdx == 0) riseIdx = idx;
        if ({csN, rasN, casN, weN} != 4'b0111) begin
          if (doneIdx > 0) postBad = 1;
          else begin
            if (nCmd < 8) begin
              cmdT[nCmd] = idx; cmdCode[nCmd] = {csN, rasN, casN, weN};
              cmdBa[nCmd] = ba; cmdAddr[nCmd] = addr;
            end
            nCmd++;
          end
        end
      end
      if (initDone && doneIdx == 0) doneIdx = idx;
      if (doneIdx > 0 && !initDone) doneDrop = 1;
      if (doneIdx > 0 && idx >= doneIdx + 6) break;
    end
  endtask

  function automatic logic [ADDR_W-1:0] modeExp(input int cl, input int bl, input int inter, input int dll);
    return ADDR_W'(bl) | ADDR_W'(inter << 3) | ADDR_W'(cl << 4) | ADDR_W'(dll << 8);
  endfunction

  task automatic verifyRun(input int expCl, input int bl, input int inter);
    int expDone;
    check(lowCnt == STABLE_CYC, "R2 cke low cycles", lowCnt, STABLE_CYC);
    check(!ckeDrop, "R2 cke stays high", ckeDrop, 0);
    check(!deselBad, "R3 deselect while cke low", deselBad, 0);
    check(nCmd == 7, "R4 command count", nCmd, 7);
    if (nCmd == 7) begin
      check(cmdCode[0] == 4'b0010, "R4 cmd0 PRE", cmdCode[0], 4'b0010);
      check(cmdCode[1] == 4'b0000 && cmdBa[1] == 2'd1, "R4 cmd1 EMRS", cmdBa[1], 1);
      check(cmdCode[2] == 4'b0000 && cmdBa[2] == 2'd0, "R4 cmd2 MRS", cmdCode[2], 0);
      check(cmdCode[3] == 4'b0010, "R4 cmd3 PRE", cmdCode[3], 4'b0010);
      check(cmdCode[4] == 4'b0001, "R4 cmd4 REF", cmdCode[4], 4'b0001);
      check(cmdCode[5] == 4'b0001, "R4 cmd5 REF", cmdCode[5], 4'b0001);
      check(cmdCode[6] == 4'b0000 && cmdBa[6] == 2'd0, "R4 cmd6 MRS", cmdCode[6], 0);
      check(cmdT[0] == riseIdx + 1, "R5 first PRE after cke", cmdT[0], riseIdx + 1);
      check(cmdT[1] - cmdT[0] == T_RP,  "R5 PRE->EMRS", cmdT[1] - cmdT[0], T_RP);
      check(cmdT[2] - cmdT[1] == T_MRD, "R5 EMRS->MRS", cmdT[2] - cmdT[1], T_MRD);
      check(cmdT[3] - cmdT[2] == T_MRD, "R5 MRS->PRE", cmdT[3] - cmdT[2], T_MRD);
      check(cmdT[4] - cmdT[3] == T_RP,  "R5 PRE->REF", cmdT[4] - cmdT[3], T_RP);
      check(cmdT[5] - cmdT[4] == T_RFC, "R5 REF->REF", cmdT[5] - cmdT[4], T_RFC);
      check(cmdT[6] - cmdT[5] == T_RFC, "R5 REF->MRS", cmdT[6] - cmdT[5], T_RFC);
      check(cmdAddr[0][10] && cmdAddr[3][10], "R6 precharge all banks", cmdAddr[3], 1024);
      check(cmdAddr[1] == ADDR_W'(DRV_HALF) << 1, "R7 EMRS word", cmdAddr[1], 2);
      check(cmdAddr[2] == modeExp(expCl, bl, inter, 1), "R8 DLL-reset MRS word",
            cmdAddr[2], modeExp(expCl, bl, inter, 1));
      check(cmdAddr[6] == modeExp(expCl, bl, inter, 0), "R8 final MRS word",
            cmdAddr[6], modeExp(expCl, bl, inter, 0));
      check(int'(cmdAddr[6][6:4]) == expCl, "R9 CAS latency", cmdAddr[6][6:4], expCl);
      expDone = (cmdT[6] + T_MRD > cmdT[2] + DLL_LOCK) ? cmdT[6] + T_MRD : cmdT[2] + DLL_LOCK;
      check(doneIdx == expDone, "R10 done time", doneIdx, expDone);
    end
    check(!doneDrop, "R10 done sticky", doneDrop, 0);
    check(!postBad, "R10 NOP after done", postBad, 0);
  endtask

  task automatic tResetState();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(cke == 1'b0, "R1 cke in reset", cke, 0);
    check(csN == 1'b1, "R1 csN in reset", csN, 1);
    check(initDone == 1'b0, "R1 done in reset", initDone, 0);
  endtask

  task automatic tExplicitCl4();
    runInit(3'd4, 3'd2, 1'b0);
    verifyRun(4, 2, 0);
  endtask

  task automatic tCl5Interleave();
    runInit(3'd5, 3'd3, 1'b1);
    verifyRun(5, 3, 1);
  endtask

  task automatic tCl3();
    runInit(3'd3, 3'd1, 1'b0);
    verifyRun(3, 1, 0);
  endtask

  task automatic tAutoCl();
    runInit(3'd0, 3'd2, 1'b1);
    verifyRun(4, 2, 1);   // R9: 4000 ps period selects 4
    runInit(3'd7, 3'd3, 1'b0);
    verifyRun(4, 3, 0);
  endtask

  task automatic tResetAfterDone();
    check(initDone == 1'b1, "R10 done before reset", initDone, 1);
    tResetState();        // R1: reset clears a completed sequence
  endtask

  initial begin
    tResetState();
    tExplicitCl4();
    tCl5Interleave();
    tCl3();
    tAutoCl();
    tResetAfterDone();
    summary();
    $finish;
  end

endmodule